// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Condition Flags

This block performs the arithmetic, logic, rotate and register step operations of a small 8-bit accumulator machine. It keeps four condition flags: sign, zero, parity and carry. The instruction sequencer presents an opcode byte, the current accumulator value and a second operand. The second operand is a general register, a memory byte or an immediate byte; for step operations it is the register being stepped. The sequencer pulses a load strobe in the cycle the instruction executes.

The result and its write-enable are combinational from the inputs and the current flags. The flags are registered on the rising clock edge while the strobe is high. Each opcode class updates only its own subset of flags. No flag is visible as a software register.

Top module: `accAluTop`

## Requirements
- R1: While `rstN` is low, all four flags are 0, and they stay 0 until the first strobed operation after reset is released.
- R2: For opcodes 0x80 to 0xBF, bits 5:3 select the operation, with `operand` as the second input: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare. `result` is the 8-bit outcome, and `resultWe` is 1 while `loadStb` is high, except for compare.
- R3: Opcodes of the form 00 fff 100 (0x04, 0x0C, ..., 0x3C) perform the same operation as R2 for the same bits 5:3, taking the immediate byte on `operand`.
- R4: After a strobed R2 or R3 operation or a strobed step operation, the flags take these values from `result`: sign is bit 7, zero is 1 when the result is 0x00, and parity is 1 when the result has an even number of one bits.
- R5: For add operations, carry is the carry out of bit 7. For subtract and compare, carry is the borrow, which is 1 when the accumulator is less than the operand plus the borrow-in. AND, XOR and OR clear carry. Add with carry and subtract with borrow use the current carry flag as input.
- R6: Opcode 0x02 rotates the accumulator left and copies bit 7 into carry. 0x0A rotates it right and copies bit 0 into carry. 0x12 and 0x1A rotate left and right through carry as a 9-bit loop. `resultWe` is 1. Sign, zero and parity do not change.
- R7: Opcodes 00 rrr 000 (increment) and 00 rrr 001 (decrement), with rrr from 1 to 6, give `operand` plus or minus 1 modulo 256 on `result` with `resultWe` = 1. Carry does not change.
- R8: While `loadStb` is low, `resultWe` is 0 and no flag changes.
- R9: Any other opcode, for example 0x00, 0x38, 0xC0 or 0xFF, gives `resultWe` = 0 and leaves every flag unchanged.
- R10: Compare updates all four flags exactly as subtract would, and never asserts `resultWe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset of the flags |
| loadStb | input | 1 | Execute strobe for the current opcode |
| opcode | input | 8 | Instruction byte that selects the operation |
| accIn | input | 8 | Current accumulator value |
| operand | input | 8 | Register, memory, immediate or step operand |
| result | output | 8 | Operation result |
| resultWe | output | 1 | Write-enable for the destination |
| flagSign | output | 1 | Sign flag |
| flagZero | output | 1 | Zero flag |
| flagParity | output | 1 | Even-parity flag |
| flagCarry | output | 1 | Carry or borrow flag |

## Verification
The assertions assume that `opcode`, `accIn` and `operand` are stable and known around each rising edge where `loadStb` is high. They also assume the flags are read only after that edge. The stimulus changes every input on the falling edge only and holds it through the next rising edge. Strobed and idle cycles are interleaved, and opcodes are drawn from each class and from the undefined codes, so the hold properties are exercised as well as the update properties.

// File: rtl/accAluPkg.sv
package accAluPkg;
  typedef enum logic [1:0] {
    CLS_NONE,
    CLS_TWO,
    CLS_ROT,
    CLS_STEP
  } opClassT;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_ADC,
    OP_SUB,
    OP_SBB,
    OP_AND,
    OP_XOR,
    OP_OR,
    OP_CMP
  } aluOpT;

  typedef struct packed {
    opClassT    opClass;
    aluOpT      aluOp;
    logic [1:0] rotSel;
    logic       stepDown;
    logic       writeEn;
    logic       updSzp;
    logic       updCarry;
  } ctrlStrobeT;
endpackage

// File: rtl/accAluCtrl.sv
module accAluCtrl
  import accAluPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] opcode,
  input  logic       loadStb,
  output ctrlStrobeT ctl
);
  logic [1:0] opGroup;
  logic [2:0] opField;
  logic [2:0] opLow;
  ctrlStrobeT raw;

  assign opGroup = opcode[7:6];
  assign opField = opcode[5:3];
  assign opLow   = opcode[2:0];

  always_comb begin
    raw = '0;
    raw.opClass = CLS_NONE;
    raw.aluOp   = OP_ADD;
    if (opGroup == 2'b10 || (opGroup == 2'b00 && opLow == 3'b100)) begin
      raw.opClass  = CLS_TWO;
      raw.aluOp    = aluOpT'(opField);
      raw.writeEn  = (opField != 3'd7);
      raw.updSzp   = 1'b1;
      raw.updCarry = 1'b1;
    end else if (opGroup == 2'b00 && opLow == 3'b010 && !opField[2]) begin
      raw.opClass  = CLS_ROT;
      raw.rotSel   = opField[1:0];
      raw.writeEn  = 1'b1;
      raw.updCarry = 1'b1;
    end else if (opGroup == 2'b00 && opLow[2:1] == 2'b00 &&
                 opField != 3'd0 && opField != 3'd7) begin
      raw.opClass  = CLS_STEP;
      raw.stepDown = opLow[0];
      raw.writeEn  = 1'b1;
      raw.updSzp   = 1'b1;
    end
  end

  always_comb begin
    ctl = raw;
    ctl.writeEn  = raw.writeEn  & loadStb;
    ctl.updSzp   = raw.updSzp   & loadStb;
    ctl.updCarry = raw.updCarry & loadStb;
  end

  // R10
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opcode[7:6] == 2'b10 && opcode[5:3] == 3'd7) |-> !ctl.writeEn);

  // R8
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |-> !(ctl.writeEn || ctl.updSzp || ctl.updCarry));
endmodule

// File: rtl/accAluDatapath.sv
module accAluDatapath
  import accAluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       ctl,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] result,
  output logic             flagSign,
  output logic             flagZero,
  output logic             flagParity,
  output logic             flagCarry
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   wide;
  logic [WIDTH-1:0] resultNext;
  logic             carryNext;
  logic             carryIn;

  always_comb begin
    carryIn = ((ctl.aluOp == OP_ADC) || (ctl.aluOp == OP_SBB)) && flagCarry;
    wide = '0;
    case (ctl.aluOp)
      OP_ADD, OP_ADC:         wide = {1'b0, accIn} + {1'b0, operand} + {{WIDTH{1'b0}}, carryIn};
      OP_SUB, OP_SBB, OP_CMP: wide = {1'b0, accIn} - {1'b0, operand} - {{WIDTH{1'b0}}, carryIn};
      OP_AND:                 wide = {1'b0, accIn & operand};
      OP_XOR:                 wide = {1'b0, accIn ^ operand};
      default:                wide = {1'b0, accIn | operand};
    endcase
  end

  always_comb begin
    resultNext = wide[MSB:0];
    carryNext  = wide[WIDTH];
    case (ctl.opClass)
      CLS_ROT: begin
        case (ctl.rotSel)
          2'd0: begin resultNext = {accIn[MSB-1:0], accIn[MSB]}; carryNext = accIn[MSB]; end
          2'd1: begin resultNext = {accIn[0], accIn[MSB:1]};     carryNext = accIn[0];   end
          2'd2: begin resultNext = {accIn[MSB-1:0], flagCarry};  carryNext = accIn[MSB]; end
          default: begin resultNext = {flagCarry, accIn[MSB:1]}; carryNext = accIn[0];   end
        endcase
      end
      CLS_STEP: begin
        resultNext = ctl.stepDown ? operand - 1'b1 : operand + 1'b1;
        carryNext  = flagCarry;
      end
      default: ;
    endcase
  end

  assign result = resultNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagSign   <= 1'b0;
      flagZero   <= 1'b0;
      flagParity <= 1'b0;
      flagCarry  <= 1'b0;
    end else begin
      if (ctl.updSzp) begin
        flagSign   <= resultNext[MSB];
        flagZero   <= (resultNext == '0);
        flagParity <= ~^resultNext;
      end
      if (ctl.updCarry) flagCarry <= carryNext;
    end
  end

  // R6
  rot_szp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.opClass == CLS_ROT && ctl.updCarry) |=>
      ($stable(flagSign) && $stable(flagZero) && $stable(flagParity)));

  // R7
  step_carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.opClass == CLS_STEP && ctl.updSzp) |=> $stable(flagCarry));

  // R5
  logic_carry_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.opClass == CLS_TWO && ctl.updCarry &&
     (ctl.aluOp == OP_AND || ctl.aluOp == OP_XOR || ctl.aluOp == OP_OR)) |=> !flagCarry);

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.updSzp |=> (flagZero == ($past(result) == '0)));

  // R8
  idle_flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.updSzp && !ctl.updCarry) |=>
      ($stable(flagSign) && $stable(flagZero) && $stable(flagParity) && $stable(flagCarry)));
endmodule

// File: rtl/accAluTop.sv
module accAluTop
  import accAluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStb,
  input  logic [7:0]       opcode,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] result,
  output logic             resultWe,
  output logic             flagSign,
  output logic             flagZero,
  output logic             flagParity,
  output logic             flagCarry
);
  ctrlStrobeT ctl;

  accAluCtrl uCtrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .loadStb(loadStb), .ctl(ctl)
  );

  accAluDatapath #(.WIDTH(WIDTH)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .accIn(accIn), .operand(operand),
    .result(result), .flagSign(flagSign), .flagZero(flagZero),
    .flagParity(flagParity), .flagCarry(flagCarry)
  );

  assign resultWe = ctl.writeEn;
endmodule

// File: tb/tb_accAluTop.sv
module tb_accAluTop;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadStb = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] accIn = 8'h00;
  logic [7:0] operand = 8'h00;
  logic [7:0] result;
  logic       resultWe;
  logic       flagSign, flagZero, flagParity, flagCarry;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [3:0] expFlags = 4'b0000;

  always #10 clk = ~clk;

  accAluTop dut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .opcode(opcode),
    .accIn(accIn), .operand(operand), .result(result), .resultWe(resultWe),
    .flagSign(flagSign), .flagZero(flagZero), .flagParity(flagParity),
    .flagCarry(flagCarry)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic string classTag(input logic [7:0] op);
    if (op[7:6] == 2'b10) return (op[5:3] == 3'd7) ? "R10" : "R2";
    if (op[7:6] == 2'b00 && op[2:0] == 3'b100) return "R3";
    if (op[7:6] == 2'b00 && op[2:0] == 3'b010 && op[5:3] < 3'd4) return "R6";
    if (op[7:6] == 2'b00 && op[2:1] == 2'b00 && op[5:3] inside {[3'd1:3'd6]}) return "R7";
    return "R9";
  endfunction

  // Reference: flags packed as {sign, zero, parity, carry}
  task automatic model(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [3:0] fl, output logic we, output logic [7:0] r,
                       output logic [3:0] nf);
    logic [2:0] f;
    logic c;
    logic nc;
    logic szp;
    logic cu;
    int ia, ib;
    f = op[5:3];
    c = fl[0];
    we = 1'b0; r = 8'h00; szp = 1'b0; cu = 1'b0; nc = c;
    ia = a; ib = b;
    if (op[7:6] == 2'b10 || (op[7:6] == 2'b00 && op[2:0] == 3'b100)) begin
      szp = 1'b1; cu = 1'b1; we = (f != 3'd7);
      case (f)
        3'd0: begin r = 8'(ia + ib);     nc = (ia + ib) > 255; end
        3'd1: begin r = 8'(ia + ib + c); nc = (ia + ib + c) > 255; end
        3'd3: begin r = 8'(ia - ib - c); nc = ia < ib + c; end
        3'd4: begin r = a & b; nc = 1'b0; end
        3'd5: begin r = a ^ b; nc = 1'b0; end
        3'd6: begin r = a | b; nc = 1'b0; end
        default: begin r = 8'(ia - ib); nc = ia < ib; end
      endcase
    end else if (op[7:6] == 2'b00 && op[2:0] == 3'b010 && f < 3'd4) begin
      we = 1'b1; cu = 1'b1;
      case (f[1:0])
        2'd0: begin r = {a[6:0], a[7]}; nc = a[7]; end
        2'd1: begin r = {a[0], a[7:1]}; nc = a[0]; end
        2'd2: begin r = {a[6:0], c};    nc = a[7]; end
        default: begin r = {c, a[7:1]}; nc = a[0]; end
      endcase
    end else if (op[7:6] == 2'b00 && op[2:1] == 2'b00 && f >= 3'd1 && f <= 3'd6) begin
      we = 1'b1; szp = 1'b1;
      r = op[0] ? 8'(ib - 1) : 8'(ib + 1);
    end
    nf = fl;
    if (szp) nf[3:1] = {r[7], r == 8'h00, ~^r};
    if (cu) nf[0] = nc;
  endtask

  task automatic doOp(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic stb, input string tag);
    logic we;
    logic [7:0] r;
    logic [3:0] nf;
    @(negedge clk);
    opcode = op; accIn = a; operand = b; loadStb = stb;
    model(op, a, b, expFlags, we, r, nf);
    if (!stb) begin
      we = 1'b0;
      nf = expFlags;
    end
    #1;
    chk({tag, " we"}, {7'd0, resultWe}, {7'd0, we});
    if (we) chk({tag, " result"}, result, r);
    @(posedge clk);
    #1;
    chk({tag, " flags"}, {4'd0, flagSign, flagZero, flagParity, flagCarry}, {4'd0, nf});
    expFlags = nf;
  endtask

  function automatic logic [7:0] pickOp(input int kind);
    logic [7:0] v;
    v = 8'($urandom);
    case (kind)
      0, 1: return {2'b10, v[5:0]};
      2: return {2'b00, v[2:0], 3'b100};
      3: return {4'b0000, v[1:0], 2'b10};
      4: return {2'b00, 3'(1 + (v[7:5] % 6)), 2'b00, v[0]};
      default: return v;
    endcase
  endfunction

  initial begin
    #3000000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1: flags cleared during reset
    chk("R1 reset flags", {4'd0, flagSign, flagZero, flagParity, flagCarry}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {4'd0, flagSign, flagZero, flagParity, flagCarry}, 8'h00);

    // R5 add carry out and zero
    doOp(8'h80, 8'hFF, 8'h01, 1'b1, "R5 add wrap");
    // R5 add with carry uses carry in
    doOp(8'h88, 8'h10, 8'h20, 1'b1, "R5 adc");
    // R10 compare equal: zero set, no write, borrow clear
    doOp(8'hB8, 8'h42, 8'h42, 1'b1, "R10 cmp equal");
    // R10 compare less: borrow set
    doOp(8'h3C, 8'h01, 8'h02, 1'b1, "R10 cmp imm less");
    // R5 subtract with borrow consumes carry
    doOp(8'h98, 8'h05, 8'h05, 1'b1, "R5 sbb");
    // R4 parity odd/even through OR immediate
    doOp(8'h34, 8'h03, 8'h00, 1'b1, "R4 parity even");
    doOp(8'hB0, 8'h07, 8'h00, 1'b1, "R4 parity odd");
    // R5 logic clears carry
    doOp(8'h90, 8'h00, 8'h01, 1'b1, "R5 borrow set");
    doOp(8'hA0, 8'hF0, 8'h0F, 1'b1, "R5 and clears carry");
    // R6 rotate through carry
    doOp(8'h12, 8'h80, 8'h00, 1'b1, "R6 ral out");
    doOp(8'h12, 8'h01, 8'h00, 1'b1, "R6 ral in");
    doOp(8'h1A, 8'h00, 8'h00, 1'b1, "R6 rar");
    // R7 step wraps and keeps carry
    doOp(8'h08, 8'h00, 8'hFF, 1'b1, "R7 inc wrap");
    doOp(8'h31, 8'h00, 8'h00, 1'b1, "R7 dec wrap");
    // R8 idle strobe
    doOp(8'h80, 8'hFF, 8'hFF, 1'b0, "R8 no strobe");
    // R9 undefined codes
    doOp(8'h00, 8'h00, 8'h00, 1'b1, "R9 code 00");
    doOp(8'h38, 8'h12, 8'h00, 1'b1, "R9 code 38");
    doOp(8'hC0, 8'h00, 8'h00, 1'b1, "R9 code C0");

    for (int i = 0; i < 600; i++) begin
      logic [7:0] op;
      op = pickOp($urandom % 6);
      doOp(op, 8'($urandom), 8'($urandom), ($urandom % 5) != 0, classTag(op));
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule